// File: doc/BRIEF.md
# Configurable Parallel-to-Serial Shift Register

This block takes a parallel word and sends it out one bit per enabled clock edge. A load strobe captures the input word into an internal register that is as wide as that word. On each later enabled edge the register moves by one position, either toward its MSB or toward its LSB. A single serial output bit is taken from whichever end of the register the current direction points at.

Several compile-time parameters set the behaviour. One picks the fill rule for each shift: logical, arithmetic or circular. Other parameters set the polarity of the direction, enable and reset inputs, the clock edge the register uses, whether reset is synchronous or asynchronous, and the value that reset loads. The serial tap is a plain multiplexer that follows the direction input at once, with no clock involved, so it is valid even while a load or a reset is taking place. Nothing frames or counts the bits: the surrounding logic decides when a word is complete.

Top module: `sershift`

## Requirements
- R1: Reset loads RST_VAL into the register and takes priority over load and shift. Asynchronous kinds (RST_KIND 1 = active-high, 3 = active-low) act at once, with no clock edge, and ignore the enable. Synchronous kinds (0 = active-high, 2 = active-low) act only on an active clock edge while the enable is asserted.
- R2: When load is high on an enabled edge and reset is not active, the register takes din. Load takes priority over shifting.
- R3: On an active edge with the enable deasserted, the register keeps its value. Load and shift have no effect then. The enable is active-high when EN_POL_HIGH is 1 and active-low when it is 0.
- R4: The direction input counts as "right" when it equals DIR_POL_HIGH (1 under active-high, 0 under active-low), and as "left" otherwise. A right shift moves bit i+1 into bit i. A left shift moves bit i into bit i+1.
- R5: With SHIFT_MODE 0 (logical), a 0 fills the vacated bit in both directions.
- R6: With SHIFT_MODE 1 (arithmetic), a left shift puts 0 in the LSB, and a right shift leaves the MSB unchanged.
- R7: With SHIFT_MODE 2 (circular), a right shift moves the old LSB into the MSB, and a left shift moves the old MSB into the LSB.
- R8: sout equals the register LSB when the direction is right and the MSB when it is left. It follows a change of the direction input with no clock edge, and during load or reset it still shows the current register contents, not din.
- R9: With FALL_EDGE 0 the register updates on the rising clock edge, and with FALL_EDGE 1 it updates on the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is set by FALL_EDGE |
| clk_en | input | 1 | Clock enable; polarity set by EN_POL_HIGH |
| rst | input | 1 | Reset; kind and polarity set by RST_KIND |
| load | input | 1 | Active-high parallel load strobe |
| dir | input | 1 | Shift direction; polarity set by DIR_POL_HIGH |
| din | input | WIDTH | Parallel data word |
| sout | output | 1 | Serial output bit from the end the direction selects |

## Verification
Three copies of the block run side by side: a logical rising-edge copy with asynchronous active-low reset, an arithmetic copy with synchronous reset and active-low direction and enable, and a circular copy on the falling edge. Each shifted word is carried past its full width. This shows whether the arithmetic copy keeps copying its sign bit, whether the circular copy returns its bits, and whether the logical copy drains to zero. A wrong fill or a mirrored direction decode shows up as a wrong bit at some position. A synchronous reset issued with the enable deasserted must leave the word intact, and an asynchronous reset must appear with no clock edge. A design that gated one of these the wrong way would lose the data or would miss the reset. The serial tap is read while the direction input changes between edges and while load is held. A registered tap, or a tap that shows din, would give a stale or a wrong bit. One sample taken between the falling and the rising edge checks that only the falling-edge copy has moved.

// File: rtl/sershift.sv
module sershift #(
  parameter int WIDTH        = 8,
  parameter int SHIFT_MODE   = 0,
  parameter bit DIR_POL_HIGH = 1'b1,
  parameter bit EN_POL_HIGH  = 1'b1,
  parameter int RST_KIND     = 3,
  parameter bit FALL_EDGE    = 1'b0,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             clk_en,
  input  logic             rst,
  input  logic             load,
  input  logic             dir,
  input  logic [WIDTH-1:0] din,
  output logic             sout
);
  localparam bit RST_ASYNC = (RST_KIND == 1) || (RST_KIND == 3);
  localparam bit RST_LOW   = (RST_KIND >= 2);

  logic             eff_clk;
  logic             rst_on;
  logic             en_on;
  logic             go_right;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] nxt;
  logic             fill_r;
  logic             fill_l;

  assign eff_clk  = FALL_EDGE ? ~clk : clk;
  assign rst_on   = RST_LOW ? ~rst : rst;
  assign en_on    = EN_POL_HIGH ? clk_en : ~clk_en;
  assign go_right = DIR_POL_HIGH ? dir : ~dir;

  generate
    if (SHIFT_MODE == 2) begin : g_circ
      assign fill_r = q[0];
      assign fill_l = q[WIDTH-1];
    end else if (SHIFT_MODE == 1) begin : g_arith
      assign fill_r = q[WIDTH-1];
      assign fill_l = 1'b0;
    end else begin : g_logic
      assign fill_r = 1'b0;
      assign fill_l = 1'b0;
    end
  endgenerate

  assign nxt  = go_right ? {fill_r, q[WIDTH-1:1]} : {q[WIDTH-2:0], fill_l};
  assign sout = go_right ? q[0] : q[WIDTH-1];

  generate
    if (RST_ASYNC) begin : g_arst
      always_ff @(posedge eff_clk or posedge rst_on) begin
        if (rst_on)     q <= RST_VAL;
        else if (en_on) q <= load ? din : nxt;
      end
    end else begin : g_srst
      always_ff @(posedge eff_clk) begin
        if (en_on) begin
          if (rst_on)    q <= RST_VAL;
          else if (load) q <= din;
          else           q <= nxt;
        end
      end
    end
  endgenerate
endmodule

module sershift_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_on,
  input logic             en_on,
  input logic             load,
  input logic             go_right,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q
);
  AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (rst_on)
    (en_on && load) |=> (q == $past(din))); // R2
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst_on)
    !en_on |=> $stable(q)); // R3
  AST_RIGHT_MOVE: assert property (@(posedge clk) disable iff (rst_on)
    (en_on && !load && go_right) |=> (q[WIDTH-2:0] == $past(q[WIDTH-1:1]))); // R4
  AST_LEFT_MOVE: assert property (@(posedge clk) disable iff (rst_on)
    (en_on && !load && !go_right) |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0]))); // R4
endmodule

bind sershift sershift_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(eff_clk), .rst_on(rst_on), .en_on(en_on), .load(load),
  .go_right(go_right), .din(din), .q(q)
);

// File: tb/sershift_bench.sv
`timescale 1ns/1ps
module sershift_bench;
  localparam int W = 8;
  localparam logic [W-1:0] RV_M = 8'hA5;
  localparam logic [W-1:0] RV_A = 8'h3C;
  localparam logic [W-1:0] RV_C = 8'h81;

  logic clk = 1'b0;
  logic rst_a = 1'b0, en_a = 1'b1, right_a = 1'b0, load = 1'b0;
  logic [W-1:0] din = '0;
  logic sout_m, sout_a, sout_c;
  logic [W-1:0] em, ea, ec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sershift #(.WIDTH(W), .SHIFT_MODE(0), .DIR_POL_HIGH(1'b1), .EN_POL_HIGH(1'b1),
             .RST_KIND(3), .FALL_EDGE(1'b0), .RST_VAL(RV_M)) u_sershift (
    .clk(clk), .clk_en(en_a), .rst(~rst_a), .load(load), .dir(right_a), .din(din), .sout(sout_m));
  sershift #(.WIDTH(W), .SHIFT_MODE(1), .DIR_POL_HIGH(1'b0), .EN_POL_HIGH(1'b0),
             .RST_KIND(0), .FALL_EDGE(1'b0), .RST_VAL(RV_A)) u_sershift_arith (
    .clk(clk), .clk_en(~en_a), .rst(rst_a), .load(load), .dir(~right_a), .din(din), .sout(sout_a));
  sershift #(.WIDTH(W), .SHIFT_MODE(2), .DIR_POL_HIGH(1'b1), .EN_POL_HIGH(1'b1),
             .RST_KIND(1), .FALL_EDGE(1'b1), .RST_VAL(RV_C)) u_sershift_circ (
    .clk(clk), .clk_en(en_a), .rst(rst_a), .load(load), .dir(right_a), .din(din), .sout(sout_c));

  function automatic logic [W-1:0] shf(int mode, logic [W-1:0] v, logic r);
    logic fr, fl;
    fr = (mode == 2) ? v[0] : (mode == 1) ? v[W-1] : 1'b0;
    fl = (mode == 2) ? v[W-1] : 1'b0;
    return r ? {fr, v[W-1:1]} : {v[W-2:0], fl};
  endfunction

  function automatic logic tap(logic [W-1:0] v, logic r);
    return r ? v[0] : v[W-1];
  endfunction

  task automatic chk(string req, string who, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: got %b expected %b", req, who, $time, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "logical", sout_m, tap(em, right_a));
    chk(req, "arith", sout_a, tap(ea, right_a));
    chk(req, "circ", sout_c, tap(ec, right_a));
  endtask

  task automatic upd_m();
    if (rst_a) em = RV_M; else if (en_a) em = load ? din : shf(0, em, right_a);
  endtask
  task automatic upd_a();
    if (en_a) ea = rst_a ? RV_A : load ? din : shf(1, ea, right_a);
  endtask
  task automatic upd_c();
    if (rst_a) ec = RV_C; else if (en_a) ec = load ? din : shf(2, ec, right_a);
  endtask

  task automatic step(string req);
    @(posedge clk); #5;
    upd_m(); upd_a(); upd_c();
    chk_all(req);
  endtask

  task automatic load_word(logic [W-1:0] w, string req);
    rst_a = 0; en_a = 1; load = 1; din = w;
    step(req);
    load = 0;
  endtask

  task automatic shift_n(int n, logic r, string req);
    right_a = r;
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic t_async_reset();
    en_a = 0;
    rst_a = 1; #2;
    em = RV_M; ec = RV_C;
    chk("R1", "logical", sout_m, tap(RV_M, right_a));
    chk("R1", "circ", sout_c, tap(RV_C, right_a));
    en_a = 1;
    step("R1");
  endtask

  task automatic t_sync_needs_en();
    load_word(8'h5E, "R2");
    rst_a = 1; en_a = 0;
    step("R1");
    rst_a = 0; en_a = 1;
    shift_n(9, 1'b1, "R1");
  endtask

  task automatic t_load_priority();
    rst_a = 1; en_a = 1; load = 1; din = 8'hFF;
    step("R1");
    load_word(8'hC3, "R2");
    shift_n(10, 1'b1, "R5");
  endtask

  task automatic t_fill_modes();
    load_word(8'h80, "R2");
    shift_n(10, 1'b1, "R6");
    load_word(8'h96, "R2");
    shift_n(10, 1'b0, "R7");
    load_word(8'h01, "R2");
    shift_n(9, 1'b0, "R5");
    load_word(8'h3B, "R2");
    shift_n(3, 1'b0, "R4");
    shift_n(3, 1'b1, "R4");
  endtask

  task automatic t_hold();
    load_word(8'h6A, "R2");
    en_a = 0; load = 1; din = 8'h00;
    step("R3");
    load = 0;
    shift_n(3, 1'b1, "R3");
    en_a = 1;
    shift_n(9, 1'b1, "R3");
  endtask

  task automatic t_tap();
    load_word(8'h01, "R8");
    right_a = 0; #1; chk_all("R8");
    right_a = 1; #1; chk_all("R8");
    load = 1; din = 8'h80; #1; chk_all("R8");
    right_a = 0; #1; chk_all("R8");
    load = 0;
    rst_a = 1; #1;
    em = RV_M; ec = RV_C;
    chk("R8", "logical", sout_m, tap(RV_M, 1'b0));
    right_a = 1; #1;
    chk("R8", "circ", sout_c, tap(RV_C, 1'b1));
    chk("R8", "arith", sout_a, tap(ea, 1'b1));
    step("R8");
    rst_a = 0;
  endtask

  task automatic t_edge();
    load_word(8'h00, "R9");
    right_a = 1; load = 1; din = 8'hFF;
    #7;
    chk("R9", "circ", sout_c, 1'b1);
    chk("R9", "logical", sout_m, 1'b0);
    chk("R9", "arith", sout_a, 1'b0);
    @(posedge clk); #5;
    em = din; ea = din; ec = din;
    chk_all("R9");
    load = 0;
  endtask

  initial begin
    #1;
    t_async_reset();
    rst_a = 0;
    t_sync_needs_en();
    t_load_priority();
    t_fill_modes();
    t_hold();
    t_tap();
    t_edge();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule